// File: doc/BRIEF.md
# Test Access Port with Fault-Reporting Instruction Capture

This block is a boundary-scan style test access port for a chip's debug and production-test path. A 16-state controller runs on the test clock and follows the mode-select input. It drives a 5-bit instruction register and three data registers: a fixed identification word, a user code word and a one-bit bypass stage. Serial data enters on the data input and leaves on the data output. The output changes on the falling edge of the test clock and has an enable that is high only while a register is being shifted.

The instruction capture value is what sets this port apart from a plain one. Its two low bits are a fixed marker. Its three high bits report sticky fault flags that the surrounding logic raises with one-cycle strobes, and each flag reads as 0 when its fault has been seen. A test host reads the faults with an ordinary instruction scan. Passing through Update-IR clears the flags, and so does the asynchronous test reset.

Top module: `jtag_status_tap`

## Requirements
- R1: The controller follows the standard 16-state transition graph on each rising edge of `tck`, steered by `tms`. Pausing in Pause-DR and returning to Shift-DR through Exit2-DR resumes the shift with no bit lost or repeated.
- R2: Asserting `trst_n` low, or being in Test-Logic-Reset, makes the identification instruction (code 5'b00001) active. A data scan then returns `ID_VALUE`, LSB first.
- R3: Capture-IR loads the 5-bit value 5'b11101 when no fault is latched, so the bits shifted out on `tdo` are 1,0,1,1,1, bit 0 first.
- R4: `fault_strobe[0]`, `[1]` and `[2]` are sampled on the rising edge of `tck` and set sticky flags. In the Capture-IR value these flags appear as 0 in bits 2, 3 and 4 respectively. Bits 1:0 stay 2'b01.
- R5: The fault flags clear on the rising edge that leaves Update-IR, unless a strobe arrives on that same edge. They also clear while `trst_n` is low.
- R6: In every data register, `tdi` enters at the MSB and the LSB drives `tdo`. A bit shifted in reappears on `tdo` after as many shift cycles as the register is long.
- R7: Instruction code 5'b00011 selects the user code register, which is `UC_W` bits wide and captures `UC_VALUE`. Its default is all zeros.
- R8: Instruction code 5'b11111, and every code other than 5'b00001 and 5'b00011, selects the one-bit bypass register. The bypass register captures 0.
- R9: The active instruction changes only on the edge that leaves Update-IR, where it takes the shifted value, or in Test-Logic-Reset. Shifting the instruction register does not change the active instruction.
- R10: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, which reloads the identification instruction.
- R11: `tdo` and `tdo_oe` update on the falling edge of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR. `tdo` is 0 while `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| fault_strobe | input | 3 | One-cycle fault strobes: bit 0 output-path fault, bit 1 probe-A fault, bit 2 probe-B fault |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |

## Verification
The bench pulses each fault strobe on its own, waits several cycles and then scans the instruction register. This exposes a flag routed to the wrong capture bit, or one that does not stick, as the wrong zero bit or as no zero bit at all. A second scan right afterwards confirms the flags cleared on Update-IR, and a test-reset case confirms they also clear on reset. Data scans that run one register length past the end of the register expose a wrong shift direction or an off-by-one in the output retiming. Undefined instruction codes are scanned to show that they fall back to the one-cycle bypass rather than to a stale register. A pause in the middle of a shift and a five-cycle high-`tms` escape from Shift-DR check the controller graph and the reload of the identification instruction.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_TLR,  ST_RTI,
      ST_SDR,  ST_CDR, ST_SHDR, ST_E1DR, ST_PDR, ST_E2DR, ST_UDR,
      ST_SIR,  ST_CIR, ST_SHIR, ST_E1IR, ST_PIR, ST_E2IR, ST_UIR
   } tap_state_e;

   localparam int IR_W      = 5;
   localparam int NUM_FLT   = 3;
   localparam int MARK_W    = IR_W - NUM_FLT;

   localparam logic [IR_W-1:0]   OP_IDENT = 5'b00001;
   localparam logic [IR_W-1:0]   OP_UCODE = 5'b00011;
   localparam logic [IR_W-1:0]   OP_BYP   = 5'b11111;
   localparam logic [MARK_W-1:0] IR_MARK  = 2'b01;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_TLR:  nxt = tms ? ST_TLR  : ST_RTI;
         ST_RTI:  nxt = tms ? ST_SDR  : ST_RTI;
         ST_SDR:  nxt = tms ? ST_SIR  : ST_CDR;
         ST_CDR:  nxt = tms ? ST_E1DR : ST_SHDR;
         ST_SHDR: nxt = tms ? ST_E1DR : ST_SHDR;
         ST_E1DR: nxt = tms ? ST_UDR  : ST_PDR;
         ST_PDR:  nxt = tms ? ST_E2DR : ST_PDR;
         ST_E2DR: nxt = tms ? ST_UDR  : ST_SHDR;
         ST_UDR:  nxt = tms ? ST_SDR  : ST_RTI;
         ST_SIR:  nxt = tms ? ST_TLR  : ST_CIR;
         ST_CIR:  nxt = tms ? ST_E1IR : ST_SHIR;
         ST_SHIR: nxt = tms ? ST_E1IR : ST_SHIR;
         ST_E1IR: nxt = tms ? ST_UIR  : ST_PIR;
         ST_PIR:  nxt = tms ? ST_E2IR : ST_PIR;
         ST_E2IR: nxt = tms ? ST_UIR  : ST_SHIR;
         ST_UIR:  nxt = tms ? ST_SDR  : ST_RTI;
         default: nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= nxt;
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic               tck,
   input  logic               trst_n,
   input  tap_state_e         state,
   input  logic               tdi,
   input  logic [NUM_FLT-1:0] fault_strobe,
   output logic [IR_W-1:0]    ir_q,
   output logic [IR_W-1:0]    ir_sr,
   output logic [NUM_FLT-1:0] err_q
);

   logic [IR_W-1:0] cap_val;

   assign cap_val = {~err_q, IR_MARK};

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= {{NUM_FLT{1'b1}}, IR_MARK};
         ir_q  <= OP_IDENT;
      end else begin
         if (state == ST_CIR)       ir_sr <= cap_val;
         else if (state == ST_SHIR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
         if (state == ST_TLR)       ir_q  <= OP_IDENT;
         else if (state == ST_UIR)  ir_q  <= ir_sr;
      end
   end

   for (genvar k = 0; k < NUM_FLT; k++) begin : g_flag
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) err_q[k] <= 1'b0;
         else         err_q[k] <= fault_strobe[k] | (err_q[k] & (state != ST_UIR));
      end
   end

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg #(
   parameter int           W   = 1,
   parameter logic [W-1:0] CAP = '0
) (
   input  logic tck,
   input  logic trst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic tdi,
   output logic so
);

   logic [W-1:0] sr;

   if (W == 1) begin : g_one
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)       sr <= CAP;
         else if (cap_en)   sr <= CAP;
         else if (shift_en) sr <= tdi;
      end
   end else begin : g_many
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)       sr <= CAP;
         else if (cap_en)   sr <= CAP;
         else if (shift_en) sr <= {tdi, sr[W-1:1]};
      end
   end

   assign so = sr[0];

endmodule

// File: rtl/jtag_status_tap.sv
module jtag_status_tap
   import tap_pkg::*;
#(
   parameter int              ID_W        = 32,
   parameter logic [ID_W-1:0] ID_VALUE    = 32'h1A5C_E0F3,
   parameter int              UC_W        = 32,
   parameter logic [UC_W-1:0] UC_VALUE    = '0,
   parameter bit              TDO_NEGEDGE = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [NUM_FLT-1:0] fault_strobe,
   output logic               tdo,
   output logic               tdo_oe
);

   if (ID_W < 2)           begin : g_bad_idw  $error("ID_W must be at least 2"); end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_idv  $error("ID_VALUE bit 0 must be 1"); end
   if (UC_W < 1)           begin : g_bad_ucw  $error("UC_W must be at least 1"); end

   tap_state_e         state;
   logic [IR_W-1:0]    ir_q;
   logic [IR_W-1:0]    ir_sr;
   logic [NUM_FLT-1:0] err_q;
   logic               sel_id, sel_uc, sel_byp;
   logic               id_so, uc_so, byp_so, dr_so;
   logic               cdr, shdr, tdo_nx, oe_nx;

   tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

   tap_ir u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .fault_strobe(fault_strobe), .ir_q(ir_q), .ir_sr(ir_sr), .err_q(err_q)
   );

   assign sel_id  = (ir_q == OP_IDENT);
   assign sel_uc  = (ir_q == OP_UCODE);
   assign sel_byp = !(sel_id || sel_uc);
   assign cdr     = (state == ST_CDR);
   assign shdr    = (state == ST_SHDR);

   tap_dreg #(.W(ID_W), .CAP(ID_VALUE)) u_id (
      .tck(tck), .trst_n(trst_n), .cap_en(cdr && sel_id),
      .shift_en(shdr && sel_id), .tdi(tdi), .so(id_so)
   );

   tap_dreg #(.W(UC_W), .CAP(UC_VALUE)) u_uc (
      .tck(tck), .trst_n(trst_n), .cap_en(cdr && sel_uc),
      .shift_en(shdr && sel_uc), .tdi(tdi), .so(uc_so)
   );

   tap_dreg #(.W(1), .CAP(1'b0)) u_byp (
      .tck(tck), .trst_n(trst_n), .cap_en(cdr && sel_byp),
      .shift_en(shdr && sel_byp), .tdi(tdi), .so(byp_so)
   );

   always_comb begin
      if (sel_id)      dr_so = id_so;
      else if (sel_uc) dr_so = uc_so;
      else             dr_so = byp_so;
   end

   assign oe_nx  = (state == ST_SHIR) || shdr;
   assign tdo_nx = !oe_nx ? 1'b0 : ((state == ST_SHIR) ? ir_sr[0] : dr_so);

   if (TDO_NEGEDGE) begin : g_tdo_neg
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
         end else begin
            tdo    <= tdo_nx;
            tdo_oe <= oe_nx;
         end
      end
   end else begin : g_tdo_comb
      assign tdo    = tdo_nx;
      assign tdo_oe = oe_nx;
   end

endmodule

// File: rtl/tap_checker.sv
module tap_checker
   import tap_pkg::*;
(
   input logic               tck,
   input logic               trst_n,
   input logic               tms,
   input logic [NUM_FLT-1:0] fault_strobe,
   input logic               tdo_oe,
   input tap_state_e         state,
   input logic [IR_W-1:0]    ir_q,
   input logic [IR_W-1:0]    ir_sr,
   input logic [NUM_FLT-1:0] err_q
);

   AST_SHIFT_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_SHDR && !$past(tms)) |-> (state == ST_SHDR)); // R1

   AST_TLR_LOADS_IDENT: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_TLR) |-> (ir_q == OP_IDENT)); // R2

   AST_CAPTURE_MARK: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_CIR) |-> (ir_sr[MARK_W-1:0] == IR_MARK)); // R3

   AST_FLAG_STICKS: assert property (@(posedge tck) disable iff (!trst_n)
      ((err_q & $past(fault_strobe)) == $past(fault_strobe))); // R4

   AST_FLAG_CLEARS: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_UIR) |-> ((err_q & ~$past(fault_strobe)) == '0)); // R5

   AST_IR_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(ir_q) |-> ($past(state) == ST_UIR || $past(state) == ST_TLR)); // R9

   AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
      |-> (state == ST_TLR)); // R10

   AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (state == ST_SHIR || state == ST_SHDR)); // R11

endmodule

bind jtag_status_tap tap_checker i_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .fault_strobe(fault_strobe),
   .tdo_oe(tdo_oe), .state(state), .ir_q(ir_q), .ir_sr(ir_sr), .err_q(err_q)
);

// File: tb/test_jtag_status_tap.sv
`timescale 1ns/1ps
module test_jtag_status_tap;

   localparam logic [31:0] ID = 32'h1A5C_E0F3;
   localparam logic [4:0]  CAP_OK = 5'b11101;

   typedef struct packed {
      logic [4:0]  code;
      logic [31:0] pat;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{5'b00001, 32'hFFFF_0000, ID},
      '{5'b00011, 32'h0000_0000, 32'h0},
      '{5'b11111, 32'hA5A5_1234, (32'hA5A5_1234 << 1)},
      '{5'b00000, 32'h8000_0001, (32'h8000_0001 << 1)},
      '{5'b10110, 32'h7FFF_FFFF, (32'h7FFF_FFFF << 1)},
      '{5'b11110, 32'hC0DE_0F0F, (32'hC0DE_0F0F << 1)}
   };

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic [2:0] fault_strobe = 3'b000;
   logic       tdo, tdo_oe;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   logic last_oe;
   logic shift_oe_ok;

   always #2 tck = ~tck;

   jtag_status_tap i_jtag_status_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .fault_strobe(fault_strobe), .tdo(tdo), .tdo_oe(tdo_oe)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o);
      @(negedge tck); #1;
      o = tdo;
      last_oe = tdo_oe;
      tms = m;
      tdi = d;
   endtask

   task automatic step(input logic m);
      logic o;
      tick(m, 1'b0, o);
   endtask

   task automatic ir_scan(input logic [4:0] code, output logic [4:0] cap);
      logic o;
      step(1); step(1); step(0); step(0);
      for (int i = 0; i < 5; i++) begin
         tick(i == 4, code[i], o);
         cap[i] = o;
      end
      step(1); step(0);
   endtask

   task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic o;
      dout = '0;
      shift_oe_ok = 1'b1;
      step(1); step(0); step(0);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i], o);
         dout[i] = o;
         if (last_oe !== 1'b1) shift_oe_ok = 1'b0;
      end
      step(1); step(0);
   endtask

   task automatic pulse(input logic [2:0] v);
      @(negedge tck); #1; fault_strobe = v;
      @(negedge tck); #1; fault_strobe = 3'b000;
   endtask

   task automatic do_reset;
      @(negedge tck); #1; trst_n = 1'b0; tms = 1'b1;
      @(negedge tck); @(negedge tck); #1; trst_n = 1'b1;
      step(0);
   endtask

   initial begin : main
      logic [4:0]  cap;
      logic [63:0] dout;
      logic        o;

      repeat (3) @(negedge tck);
      #1; trst_n = 1'b1;
      check("R11 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
      check("R11 reset tdo", {63'd0, tdo}, 64'd0);
      step(0);

      dr_scan(32, 64'd0, dout);
      check("R2 ident after reset", dout[31:0], ID);
      check("R11 oe during shift", {63'd0, shift_oe_ok}, 64'd1);
      step(0);
      check("R11 oe idle", {63'd0, last_oe}, 64'd0);

      // table walk: R3 capture, R7/R8 selection, R9 update takes effect
      foreach (VECS[n]) begin
         ir_scan(VECS[n].code, cap);
         check("R3 capture pattern", cap, CAP_OK);
         dr_scan(32, {32'd0, VECS[n].pat}, dout);
         check("R9/R7/R8 dr after update", dout[31:0], VECS[n].exp);
      end

      // R6 data passes through ident register after its length
      ir_scan(5'b00001, cap);
      dr_scan(64, {32'd0, 32'hC3C3_5A5A}, dout);
      check("R6 ident front", dout[31:0], ID);
      check("R6 ident passthrough", dout[63:32], 32'hC3C3_5A5A);

      // R6 user code register pass-through
      ir_scan(5'b00011, cap);
      dr_scan(64, {32'd0, 32'h1234_ABCD}, dout);
      check("R7 ucode zero", dout[31:0], 32'h0);
      check("R6 ucode passthrough", dout[63:32], 32'h1234_ABCD);

      // R4 each flag sticky, R5 cleared by update
      for (int k = 0; k < 3; k++) begin
         pulse(3'b001 << k);
         repeat (4) step(0);
         ir_scan(5'b11111, cap);
         check("R4 flag capture", cap, CAP_OK & ~(5'b00100 << k));
         ir_scan(5'b11111, cap);
         check("R5 cleared by update", cap, CAP_OK);
      end
      pulse(3'b111);
      ir_scan(5'b11111, cap);
      check("R4 all flags", cap, 5'b00001);

      // R5 cleared by test reset
      pulse(3'b010);
      do_reset();
      ir_scan(5'b11111, cap);
      check("R5 cleared by trst", cap, CAP_OK);

      // R1 pause in mid-shift of ident register
      ir_scan(5'b00001, cap);
      dout = '0;
      step(1); step(0); step(0);
      for (int i = 0; i < 10; i++) begin tick(i == 9, 1'b0, o); dout[i] = o; end
      step(0); step(0);
      check("R1 oe low in pause", {63'd0, last_oe}, 64'd0);
      step(1); step(0);
      for (int i = 10; i < 32; i++) begin tick(i == 31, 1'b0, o); dout[i] = o; end
      step(1); step(0);
      check("R1 pause resume", dout[31:0], ID);

      // R10 escape from Shift-DR with user code active
      ir_scan(5'b00011, cap);
      step(1); step(0); step(0);
      repeat (5) step(1);
      step(0);
      dr_scan(32, 64'd0, dout);
      check("R10 five high to reset", dout[31:0], ID);

      // R10 escape from Pause-IR after shifting a bypass code
      step(1); step(1); step(0); step(0);
      for (int i = 0; i < 5; i++) tick(i == 4, 1'b1, o);
      step(0);
      repeat (5) step(1);
      step(0);
      dr_scan(32, 64'd0, dout);
      check("R10 R9 escape from pause-ir", dout[31:0], ID);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge tck);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule